// File: doc/BRIEF.md
# Ring Pulse Train Detector

This block watches an active-low telephone ring line and produces a one-cycle wake event when an incoming call is present. It runs from a 32.768 kHz time base, which it divides into fixed slots of 2048 cycles (62.5 ms). For each slot it records whether at least one falling edge reached the detector. A short history of these occupancy bits slides along at every slot boundary. A train is recognised when the slot that has just closed and the two slots before it all held edges, and the slot before those three held none.

A mode input selects the behaviour of the output. In edge mode every falling edge on the ring line gives an event. In train mode only a qualifying pulse train gives an event. Under this rule a train at 16 Hz or faster, lasting about 0.19 s, is always caught. A train slower than about 11 Hz can never fill three slots in a row, so it is never caught. The ring input is asynchronous and passes through a synchroniser before edge detection.

Top module: `ring_wake_detect`

## Requirements
- R1: While reset is high and in the first cycle after it is released, the event output is 0. Reset empties the slot history and restarts the slot counter, and slots before reset count as empty.
- R2: The ring input passes through SYNC_STAGES flops (default 2). A falling edge is a 1 followed by a 0 on consecutive synchronised samples, and it is never flagged in two cycles in a row.
- R3: With mode_sel_i = 0 (edge mode), each falling edge on ring_n_i gives a ring_evt_o pulse of exactly one cycle. The pulse is high after the third rising clock edge that follows the change of the input.
- R4: Slots are SLOT_CYCLES cycles long and are counted from reset release. Slot k covers clock edges k*SLOT_CYCLES+1 to (k+1)*SLOT_CYCLES. An input fall driven after edge n counts in slot floor((n+2)/SLOT_CYCLES).
- R5: With mode_sel_i = 1 (train mode), ring_evt_o is high for the one cycle that follows edge k*SLOT_CYCLES (k ≥ 1) when slots k-1, k-2 and k-3 each held a falling edge and slot k-4 held none.
- R6: After a train event, no further train event occurs until a slot with no edge has closed. An unbroken train therefore gives exactly one event, and two bursts separated by one empty slot give two events.
- R7: In train mode, falling edges spaced exactly SLOT_CYCLES apart always produce an event.
- R8: In train mode, falling edges spaced more than 1.5 slots apart never produce an event.
- R9: In train mode, an isolated single falling edge produces no event.
- R10: With the mode held constant, ring_evt_o is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz time-base clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_n_i | input | 1 | Asynchronous active-low ring line |
| mode_sel_i | input | 1 | 0: event on each falling edge, 1: event on pulse train |
| ring_evt_o | output | 1 | Registered one-cycle detect event |

## Verification
The hardest case to reach from the ports is an edge that lands right at a slot boundary. Whether such an edge opens a new slot depends on the two-cycle synchroniser delay. A reference model in the bench places each fall into the slot given by R4 and checks the output on every cycle. Random stimulus enables ring activity in randomly chosen slots, which creates many falls at slot edges and patterns of empty and occupied slots. Directed runs at an exact one-slot period, at a period longer than 1.5 slots, with a lone edge, and with two bursts separated by one empty slot cover the rate limits and the re-arm rule.

// File: rtl/ring_wake_pkg.sv
package ring_wake_pkg;
  typedef enum logic {
    DET_EDGE  = 1'b0,
    DET_TRAIN = 1'b1
  } det_mode_e;
endpackage

// File: rtl/ring_edge_sync.sv
module ring_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ring_n_i,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  // idle level of the ring line is high, so flops reset to 1
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ring_n_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[SYNC_STAGES-1];

  p_fall_single_r2: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);
endmodule

// File: rtl/ring_slot_timer.sv
module ring_slot_timer #(
  parameter int SLOT_CYCLES = 2048
) (
  input  logic clk,
  input  logic rst,
  output logic slot_end_o
);
  localparam int CNT_W = (SLOT_CYCLES > 2) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)             cnt_q <= '0;
    else if (slot_end_o) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  assign slot_end_o = (cnt_q == LAST);

  p_slot_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    slot_end_o |=> (cnt_q == '0));
  p_slot_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/ring_slot_history.sv
module ring_slot_history #(
  parameter int RUN_SLOTS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic fall_i,
  input  logic slot_end_i,
  output logic train_hit_o
);
  localparam int HIST_W = RUN_SLOTS + 1;
  // oldest slot empty, newest RUN_SLOTS slots occupied (bit 0 newest)
  localparam logic [HIST_W-1:0] TRAIN_PAT = {1'b0, {RUN_SLOTS{1'b1}}};

  logic              occ_q;
  logic              armed_q;
  logic [HIST_W-1:0] hist_q;
  logic              cur_occ;
  logic [HIST_W-1:0] next_hist;

  assign cur_occ     = occ_q | fall_i;
  assign next_hist   = {hist_q[HIST_W-2:0], cur_occ};
  assign train_hit_o = slot_end_i & armed_q & (next_hist == TRAIN_PAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q   <= 1'b0;
      armed_q <= 1'b1;
      hist_q  <= '0;
    end else if (slot_end_i) begin
      occ_q  <= 1'b0;
      hist_q <= next_hist;
      if (train_hit_o)   armed_q <= 1'b0;
      else if (!cur_occ) armed_q <= 1'b1;
    end else if (fall_i) begin
      occ_q <= 1'b1;
    end
  end

  p_hit_on_boundary_r5: assert property (@(posedge clk) disable iff (rst)
    train_hit_o |-> slot_end_i);
  p_hit_disarms_r6: assert property (@(posedge clk) disable iff (rst)
    train_hit_o |=> !armed_q);
endmodule

// File: rtl/ring_wake_detect.sv
module ring_wake_detect #(
  parameter int SLOT_CYCLES = 2048,
  parameter int SYNC_STAGES = 2,
  parameter int RUN_SLOTS   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic ring_n_i,
  input  logic mode_sel_i,
  output logic ring_evt_o
);
  import ring_wake_pkg::*;

  logic      fall;
  logic      slot_end;
  logic      train_hit;
  det_mode_e mode;
  logic      evt_q;

  assign mode = det_mode_e'(mode_sel_i);

  ring_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ring_n_i(ring_n_i), .fall_o(fall));

  ring_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .slot_end_o(slot_end));

  ring_slot_history #(.RUN_SLOTS(RUN_SLOTS)) u_hist (
    .clk(clk), .rst(rst), .fall_i(fall), .slot_end_i(slot_end),
    .train_hit_o(train_hit));

  always_ff @(posedge clk) begin
    if (rst) evt_q <= 1'b0;
    else     evt_q <= (mode == DET_TRAIN) ? train_hit : fall;
  end

  assign ring_evt_o = evt_q;

  p_edge_latency_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == DET_EDGE && fall) |=> ring_evt_o);
  p_train_aligned_r5: assert property (@(posedge clk) disable iff (rst)
    (ring_evt_o && $past(mode_sel_i)) |-> $past(slot_end));
  p_pulse_width_r10: assert property (@(posedge clk) disable iff (rst)
    (ring_evt_o && $stable(mode_sel_i)) |=> !ring_evt_o);
endmodule

// File: tb/tb_ring_wake_detect.sv
module tb_ring_wake_detect;
  localparam int SLOT    = 64;
  localparam int RUN_MAX = 4096;
  localparam int NSLOT   = RUN_MAX / SLOT + 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ring_n = 1'b1;
  logic mode = 1'b0;
  logic evt;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int ev_cnt = 0;
  bit done = 1'b0;
  bit exp_edge [0:RUN_MAX+8];
  bit occ      [0:NSLOT-1];
  bit act      [0:NSLOT-1];

  ring_wake_detect #(.SLOT_CYCLES(SLOT)) dut (
    .clk(clk), .rst(rst), .ring_n_i(ring_n), .mode_sel_i(mode), .ring_evt_o(evt));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  function automatic bit occ_at(int s);
    return (s < 0) ? 1'b0 : occ[s];
  endfunction

  // R5 model: event after edge k*SLOT when slots k-1..k-3 busy, k-4 empty
  function automatic bit train_exp(int c);
    int k;
    if (c <= 0 || (c % SLOT) != 0) return 1'b0;
    k = c / SLOT;
    return occ_at(k-1) && occ_at(k-2) && occ_at(k-3) && !occ_at(k-4);
  endfunction

  task automatic check(string req, bit act_v, bit exp_v);
    tests++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%0b expected=%0b", req, cyc, act_v, exp_v);
    end
  endtask

  task automatic do_reset(bit m);
    rst = 1'b1;
    ring_n = 1'b1;
    mode = m;
    ev_cnt = 0;
    for (int i = 0; i <= RUN_MAX + 8; i++) exp_edge[i] = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin occ[i] = 1'b0; act[i] = 1'b0; end
    repeat (3) @(negedge clk);
    check("R1", evt, 1'b0);
    rst = 1'b0;
  endtask

  // one cycle: check output for edge just passed, then drive the line
  task automatic tick(bit v);
    bit e;
    @(negedge clk);
    e = mode ? train_exp(cyc) : exp_edge[cyc];
    check(mode ? "R5" : "R3", evt, e);
    if (evt) ev_cnt++;
    if (ring_n == 1'b1 && v == 1'b0) begin
      occ[(cyc + 2) / SLOT] = 1'b1;   // R4 slot assignment
      exp_edge[cyc + 3] = 1'b1;       // R3 latency
    end
    ring_n = v;
  endtask

  task automatic run_period(int period, int len);
    for (int i = 0; i < len; i++) tick((i % period) < 4 ? 1'b0 : 1'b1);
  endtask

  task automatic run_random(int len, int pct);
    for (int s = 0; s < NSLOT; s++) act[s] = (($urandom % 100) < pct);
    for (int i = 0; i < len; i++) begin
      bit v;
      if (ring_n == 1'b0)            v = (($urandom % 3) == 0);
      else if (act[(cyc + 2) / SLOT]) v = (($urandom % 12) != 0);
      else                           v = 1'b1;
      tick(v);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));

    // R1 R3 R2: edge mode random activity
    do_reset(1'b0);
    run_random(2000, 60);

    // R3: one lone edge gives exactly one pulse
    do_reset(1'b0);
    repeat (20) tick(1'b1);
    repeat (5) tick(1'b0);
    repeat (40) tick(1'b1);
    check("R3", ev_cnt == 1, 1'b1);

    // R7 R6: edges every slot, continuous train yields one event
    do_reset(1'b1);
    run_period(SLOT, 1500);
    check("R7", ev_cnt >= 1, 1'b1);
    check("R6", ev_cnt == 1, 1'b1);

    // R8: spacing above 1.5 slots never detected
    do_reset(1'b1);
    run_period(100, 2500);
    check("R8", ev_cnt == 0, 1'b1);

    // R9: single edge in train mode ignored
    do_reset(1'b1);
    repeat (30) tick(1'b1);
    repeat (4) tick(1'b0);
    repeat (600) tick(1'b1);
    check("R9", ev_cnt == 0, 1'b1);

    // R6: two bursts of three slots split by one empty slot
    do_reset(1'b1);
    for (int i = 0; i < 9 * SLOT; i++) begin
      int s;
      s = (cyc + 3) / SLOT;
      if (s == 3 || s >= 7) tick(1'b1);
      else                  tick(((cyc + 3) % 16) < 4 ? 1'b0 : 1'b1);
    end
    check("R6", ev_cnt == 2, 1'b1);

    // R4 R5 R10: random slot occupancy in train mode
    for (int r = 0; r < 6; r++) begin
      do_reset(1'b1);
      run_random(3000, 55 + 8 * r);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule